// File: doc/BRIEF.md
# Strobe-Captured Word Serializer

This block turns a 24-bit parallel word into a source-synchronous serial frame. A word is formed from 22 general data bits and 2 auxiliary bits. It is latched when a rising edge of an asynchronous strobe is seen in the bit-clock domain. The word is then shifted out one bit per slot. Each slot is accompanied by a bit-enable pulse that a link partner uses as its sampling clock. The bit clock is a plain input: clock synthesis and line signaling sit outside the block.

The reference clock normally runs faster than the strobe. Whenever no word is waiting, the block fills the slots between frames with zeros. A single holding register lets the next word arrive while the current frame is still on the line. A strobe edge that finds that register still occupied raises a sticky overrun flag, and the older word is kept. In half-rate mode every slot is stretched to two bit-clock cycles, which halves the line rate. Strobe edges that arrive while the reference is reported unlocked are dropped.

Top module: `strobe_ser_top`

## Requirements
- R1: While rst_ni is low, ser_o, bit_en_o and overrun_o are all 0.
- R2: A rising edge of strobe_i, once locked_i is 1, captures the word {aux_i, data_i}, with aux_i as bits 23:22. The capture happens in the third bit-clock edge after the strobe is first sampled high, and the inputs must stay stable until then. A strobe held high yields exactly one word.
- R3: A frame is 26 slots on ser_o. Slot 0 is 1 (start). Slots 1 to 24 carry word bits 0 to 23, least significant first. Slot 25 is 0 (stop).
- R4: Every slot that belongs to no frame carries 0 on ser_o, so idle line time never looks like a start bit.
- R5: With half_rate_i low, each slot lasts one bit-clock cycle and bit_en_o is 1 in every cycle.
- R6: With half_rate_i high, each slot lasts two bit-clock cycles. bit_en_o is 1 only in the first cycle of each slot, and ser_o is constant within a slot.
- R7: One captured word can wait while a frame is being sent. Its start slot follows the previous frame's stop slot directly, so the two start slots are exactly 26 slots apart.
- R8: A strobe edge that arrives while a word is still waiting sets overrun_o, and the waiting word is kept. The new word is discarded. overrun_o stays 1 until reset.
- R9: Strobe edges seen while locked_i is 0 are ignored and produce no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| locked_i | input | 1 | Reference clock is stable; strobes are accepted only while high |
| half_rate_i | input | 1 | 1 stretches every slot to two cycles |
| strobe_i | input | 1 | Asynchronous word strobe, rising edge captures |
| data_i | input | 22 | General data bits, word bits 21:0 |
| aux_i | input | 2 | Auxiliary bits, word bits 23:22 |
| ser_o | output | 1 | Serial data, one bit per slot |
| bit_en_o | output | 1 | High in the first cycle of each slot |
| overrun_o | output | 1 | Sticky flag: a strobe arrived while a word was waiting |

## Verification
Some behaviours are checked by the assertions on every cycle. These are the reset values, the constant enable in full-rate mode, the alternating enable and the stable serial bit within a stretched slot in half-rate mode, and the stickiness of the overrun flag. Other behaviours can only be shown by the bench's scenarios. These are the frame layout and bit order, idle zero fill, back-to-back spacing through the holding register, which word survives an overrun, the single capture for a long strobe, and the dropping of strobes while unlocked. The bench covers them with a behavioural slot model compared every cycle and with a frame decoder that reads the serial line.

// File: rtl/strobe_ser_pkg.sv
package strobe_ser_pkg;
  localparam int unsigned DATA_W_DEF  = 22;
  localparam int unsigned AUX_W_DEF   = 2;
  localparam int unsigned SYNC_N_DEF  = 2;
  // start + stop slots around the word
  localparam int unsigned FRAME_EXTRA = 2;

  function automatic int unsigned frame_len(input int unsigned word_w);
    return word_w + FRAME_EXTRA;
  endfunction
endpackage

// File: rtl/strobe_ser_sync.sv
module strobe_ser_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q[0] <= 1'b0;
    else         q[0] <= async_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q[i] <= 1'b0;
      else         q[i] <= q[i-1];
    end
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/strobe_ser_slot_timer.sv
module strobe_ser_slot_timer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_rate_i,
  output logic tick_o,
  output logic bit_en_o
);
  logic phase_q;

  // tick ends a slot; in half-rate mode only every second cycle
  assign tick_o = ~half_rate_i | phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= 1'b0;
      bit_en_o <= 1'b0;
    end else begin
      phase_q  <= half_rate_i ? ~phase_q : 1'b0;
      bit_en_o <= tick_o;
    end
  end
endmodule

// File: rtl/strobe_ser_holder.sv
module strobe_ser_holder #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              enable_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o,
  output logic              overrun_o
);
  logic edge_ok, accept, collide;

  assign edge_ok = rise_i & enable_i;
  assign accept  = edge_ok & (~full_o | take_i);
  assign collide = edge_ok & full_o & ~take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o    <= 1'b0;
      word_o    <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (accept) begin
        word_o <= word_i;
        full_o <= 1'b1;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
      if (collide) overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_ser_shifter.sv
module strobe_ser_shifter #(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              full_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              take_o,
  output logic              ser_o
);
  localparam int unsigned FRAME_W = strobe_ser_pkg::frame_len(WORD_W);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   left_q;
  logic               last_slot;

  assign last_slot = (left_q <= CNT_W'(1));
  assign take_o    = tick_i & last_slot & full_i;
  assign ser_o     = shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      left_q  <= '0;
    end else if (tick_i) begin
      if (!last_slot) begin
        shreg_q <= {1'b0, shreg_q[FRAME_W-1:1]};
        left_q  <= left_q - CNT_W'(1);
      end else if (full_i) begin
        shreg_q <= {1'b0, word_i, 1'b1};
        left_q  <= CNT_W'(FRAME_W);
      end else begin
        shreg_q <= '0;
        left_q  <= '0;
      end
    end
  end
endmodule

// File: rtl/strobe_ser_top.sv
module strobe_ser_top #(
  parameter int unsigned DATA_W = strobe_ser_pkg::DATA_W_DEF,
  parameter int unsigned AUX_W  = strobe_ser_pkg::AUX_W_DEF,
  parameter int unsigned SYNC_N = strobe_ser_pkg::SYNC_N_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              locked_i,
  input  logic              half_rate_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AUX_W-1:0]  aux_i,
  output logic              ser_o,
  output logic              bit_en_o,
  output logic              overrun_o
);
  localparam int unsigned WORD_W = DATA_W + AUX_W;

  logic              rise, tick, take, full;
  logic [WORD_W-1:0] held;

  strobe_ser_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(strobe_i), .rise_o(rise)
  );

  strobe_ser_slot_timer u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_rate_i(half_rate_i),
    .tick_o(tick), .bit_en_o(bit_en_o)
  );

  strobe_ser_holder #(.WORD_W(WORD_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .enable_i(locked_i),
    .word_i({aux_i, data_i}), .take_i(take), .full_o(full),
    .word_o(held), .overrun_o(overrun_o)
  );

  strobe_ser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .full_i(full),
    .word_i(held), .take_o(take), .ser_o(ser_o)
  );
endmodule

// File: rtl/strobe_ser_chk.sv
module strobe_ser_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic half_rate_i,
  input logic ser_o,
  input logic bit_en_o,
  input logic overrun_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!ser_o && !bit_en_o && !overrun_o)
        else $error("R1 outputs not idle in reset");
    end
  end

  a_r5_full_rate_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !half_rate_i |=> bit_en_o);

  a_r6_half_rate_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_rate_i && $past(half_rate_i) && bit_en_o) |=> !bit_en_o);

  a_r6_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_o |-> $stable(ser_o));

  a_r8_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind strobe_ser_top strobe_ser_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .half_rate_i(half_rate_i),
  .ser_o(ser_o), .bit_en_o(bit_en_o), .overrun_o(overrun_o)
);

// File: tb/strobe_ser_top_tb.sv
module strobe_ser_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni, locked, half, strobe;
  logic [21:0] data;
  logic [1:0]  aux;
  logic        ser, ben, ovr;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  strobe_ser_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .locked_i(locked), .half_rate_i(half),
    .strobe_i(strobe), .data_i(data), .aux_i(aux),
    .ser_o(ser), .bit_en_o(ben), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural slot model
  bit          m_sa, m_sb, m_sc, m_ph, m_pv, m_ovr, m_en, m_ser;
  logic [23:0] m_pw, m_fw;
  int          m_rem, m_idx;

  function automatic bit slot_bit(input logic [23:0] w, input int i);
    if (i == 0) return 1'b1;
    if (i == 25) return 1'b0;
    return w[i-1];
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sa = 0; m_sb = 0; m_sc = 0; m_ph = 0; m_pv = 0; m_ovr = 0;
      m_en = 0; m_ser = 0; m_pw = '0; m_fw = '0; m_rem = 0; m_idx = 0;
    end else begin
      bit tick, edge_seen, take;
      tick      = !half || m_ph;
      edge_seen = m_sb && !m_sc;
      take      = tick && m_rem <= 1 && m_pv;
      if (tick) begin
        if (m_rem > 1) begin m_idx++; m_rem--; end
        else if (take) begin m_fw = m_pw; m_idx = 0; m_rem = 26; end
        else m_rem = 0;
      end
      if (take) m_pv = 0;
      if (edge_seen && locked) begin
        if (!m_pv) begin m_pw = {aux, data}; m_pv = 1; end
        else m_ovr = 1;
      end
      m_ph = half ? !m_ph : 1'b0;
      m_sc = m_sb; m_sb = m_sa; m_sa = strobe;
      m_en = tick;
      m_ser = (m_rem > 0) ? slot_bit(m_fw, m_idx) : 1'b0;
    end
  end

  // line decoder
  logic [23:0] rx_q[$];
  int          rx_slot[$];
  int          slot_no = 0, pos = 0;
  bit          in_frame = 0;
  logic [23:0] rx_w;

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      if (cycles > 20000) begin
        chk(0, "R0", "watchdog expired", cycles, 20000);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
      if (rst_ni) begin
        chk(ser == m_ser, "R3", "ser_o vs model", ser, m_ser);
        chk(ben == m_en, half ? "R6" : "R5", "bit_en_o vs model", ben, m_en);
        chk(ovr == m_ovr, "R8", "overrun_o vs model", ovr, m_ovr);
        if (ben) begin
          slot_no++;
          if (!in_frame) begin
            if (ser) begin in_frame = 1; pos = 0; rx_slot.push_back(slot_no); end
          end else begin
            pos++;
            if (pos <= 24) rx_w[pos-1] = ser;
            else begin
              chk(ser == 1'b0, "R3", "stop slot", ser, 0);
              rx_q.push_back(rx_w);
              in_frame = 0;
            end
          end
        end
      end else in_frame = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] w, input int high_cycles);
    @(negedge clk);
    data = w[21:0]; aux = w[23:22]; strobe = 1'b1;
    cyc(high_cycles);
    strobe = 1'b0;
    cyc(3);
  endtask

  initial begin
    int base;
    rst_ni = 1; locked = 0; half = 0; strobe = 0; data = '0; aux = '0;
    #1 rst_ni = 0;
    cyc(3);
    chk(ser == 0, "R1", "ser_o in reset", ser, 0);
    chk(ben == 0, "R1", "bit_en_o in reset", ben, 0);
    chk(ovr == 0, "R1", "overrun_o in reset", ovr, 0);
    rst_ni = 1;
    cyc(4);

    // R9: unlocked strobe ignored
    send(24'h00F00F, 4);
    cyc(40);
    chk(rx_q.size() == 0, "R9", "frames while unlocked", rx_q.size(), 0);
    locked = 1;
    cyc(2);

    // R2/R3: single word, aux in top bits
    send(24'hC5A3E1, 4);
    cyc(40);
    chk(rx_q.size() == 1, "R2", "frame count", rx_q.size(), 1);
    if (rx_q.size() >= 1) chk(rx_q[0] == 24'hC5A3E1, "R3", "decoded word", rx_q[0], 24'hC5A3E1);

    // R4: idle line is zero
    for (int i = 0; i < 30; i++) begin
      cyc(1);
      chk(ser == 1'b0, "R4", "idle ser_o", ser, 0);
    end

    // R7: back-to-back through the holding register
    base = rx_q.size();
    send(24'h3C0FF0, 4);
    send(24'h81247E, 4);
    cyc(70);
    chk(rx_q.size() == base + 2, "R7", "frame count", rx_q.size(), base + 2);
    if (rx_q.size() >= base + 2) begin
      chk(rx_q[base] == 24'h3C0FF0, "R7", "first word", rx_q[base], 24'h3C0FF0);
      chk(rx_q[base+1] == 24'h81247E, "R7", "second word", rx_q[base+1], 24'h81247E);
      chk(rx_slot[base+1] - rx_slot[base] == 26, "R7", "start spacing",
          rx_slot[base+1] - rx_slot[base], 26);
    end

    // R2: long strobe gives one word
    base = rx_q.size();
    send(24'h5AA5C3, 50);
    cyc(40);
    chk(rx_q.size() == base + 1, "R2", "long strobe frames", rx_q.size(), base + 1);

    // R8: overrun keeps the waiting word
    base = rx_q.size();
    chk(ovr == 0, "R8", "overrun before", ovr, 0);
    send(24'h111111, 4);
    send(24'h222222, 4);
    send(24'h333333, 4);
    cyc(70);
    chk(ovr == 1, "R8", "overrun set", ovr, 1);
    chk(rx_q.size() == base + 2, "R8", "frames after overrun", rx_q.size(), base + 2);
    if (rx_q.size() >= base + 2)
      chk(rx_q[base+1] == 24'h222222, "R8", "kept older word", rx_q[base+1], 24'h222222);
    cyc(20);
    chk(ovr == 1, "R8", "overrun sticky", ovr, 1);

    // R6: half-rate mode
    half = 1;
    cyc(4);
    base = rx_q.size();
    send(24'h9E3701, 4);
    cyc(70);
    chk(rx_q.size() == base + 1, "R6", "half-rate frame count", rx_q.size(), base + 1);
    if (rx_q.size() >= base + 1)
      chk(rx_q[base] == 24'h9E3701, "R6", "half-rate word", rx_q[base], 24'h9E3701);
    half = 0;
    cyc(4);

    // R1/R8: reset clears overrun
    rst_ni = 0;
    cyc(2);
    chk(ovr == 0, "R1", "overrun cleared by reset", ovr, 0);
    rst_ni = 1;
    cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule